// File: doc/BRIEF.md
# Paired PWM Output Stage

This block turns one shared up-counter value and six per-channel pulse-width values into six registered PWM outputs. The outputs are grouped into three pairs: channels 0 and 1, 2 and 3, and 4 and 5. In each pair the even channel is the top side and the odd channel is the bottom side. A pair either runs as two independent channels, or as a complementary pair in which the bottom side is driven from the inverse of the top side's compare result.

Each output has its own polarity select. A small configuration register holds the per-pair mode bits and the per-side polarity bits. It is loaded through a plain write strobe. A separate lock flag can be set once, and after that the configuration is frozen until reset. The counter itself, deadtime handling and fault shutdown live outside this block.

Top module: `pwm_pair_stage`

## Requirements
- R1: With polarity bit 0 (positive), a channel's raw compare result is 1 while `cnt_i` is less than or equal to its pulse width, and 0 otherwise. The output follows the raw result.
- R2: With polarity bit 1 (negative), the output is the inverse of the raw result: it is low while `cnt_i` is at or below the width, and high above it.
- R3: With a pair's mode bit at 0 (complementary), the bottom raw signal is the inverse of the top channel's raw compare result. The bottom channel's own width has no effect on the output.
- R4: With a pair's mode bit at 1 (independent), the bottom channel compares `cnt_i` against its own width.
- R5: Configuration word layout. Bit 2p is the top-side polarity of pair p and bit 2p+1 is its bottom-side polarity, so bit 0 is top A and bit 5 is bottom C. Bit 6+p is the mode bit of pair p (A=0, B=1, C=2). Output bit n is channel n.
- R6: After reset the configuration word is 0 (complementary, positive), the lock flag is 0 and all outputs are low.
- R7: The lock flag is set by `wp_set_i`. Only reset clears it. Once the flag reads 1, configuration writes are ignored. A write in the same cycle as `wp_set_i` is still accepted.
- R8: Outputs are registered. A change on `cnt_i` or on the widths shows at `pwm_o` after the next rising clock edge, and not before it.
- R9: The equality boundary counts as "at or below": a width equal to the counter gives a raw 1, a width one below the counter gives a raw 0, and the maximum width gives a raw 1 for every counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Shared counter value |
| width_i | input | N_PAIRS*2*CNT_W | Pulse widths, channel n at bits [n*CNT_W +: CNT_W] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3*N_PAIRS | Configuration write data (layout in R5) |
| wp_set_i | input | 1 | Sets the configuration lock |
| cfg_rdata_o | output | 3*N_PAIRS | Current configuration word |
| wp_o | output | 1 | Lock flag |
| pwm_o | output | N_PAIRS*2 | Registered PWM outputs, bit n is channel n |

## Verification
A configuration write and the lock request can arrive in the same cycle. The bench drives `cfg_we_i` and `wp_set_i` together. It then expects the written word to appear on `cfg_rdata_o` with the lock flag set, and it expects every later write to leave both the word and the PWM pattern unchanged. A mode or polarity change also falls in the same cycle as a counter move. The table walk therefore holds each new setting for two edges and judges the output only after the edge that uses the new configuration.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {
    PAIR_COMPL = 1'b0,
    PAIR_INDEP = 1'b1
  } pair_mode_e;

  typedef struct packed {
    logic pol_bot;
    logic pol_top;
  } pair_pol_t;

  function automatic int pol_bit(input int pair, input logic bottom);
    return 2 * pair + int'(bottom);
  endfunction
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg #(
  parameter int N_PAIRS = 3,
  localparam int CFG_W = 3 * N_PAIRS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wp_set_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             wp_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      wp_q  <= 1'b0;
    end else begin
      // lock is checked on the registered flag, so a same-cycle write lands
      if (we_i && !wp_q) cfg_q <= wdata_i;
      if (wp_set_i) wp_q <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;
  assign wp_o  = wp_q;
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             raw_o
);
  assign raw_o = (cnt_i <= width_i);
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out
  import pwm_pair_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pair_mode_e mode_i,
  input  pair_pol_t  pol_i,
  input  logic       raw_top_i,
  input  logic       raw_bot_i,
  output logic       top_o,
  output logic       bot_o
);
  logic bot_src;
  logic top_d, bot_d;
  logic top_q, bot_q;

  always_comb begin
    bot_src = (mode_i == PAIR_INDEP) ? raw_bot_i : ~raw_top_i;
    top_d   = raw_top_i ^ pol_i.pol_top;
    bot_d   = bot_src ^ pol_i.pol_bot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= 1'b0;
      bot_q <= 1'b0;
    end else begin
      top_q <= top_d;
      bot_q <= bot_d;
    end
  end

  assign top_o = top_q;
  assign bot_o = bot_q;
endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int N_PAIRS = 3,
  localparam int N_CH   = 2 * N_PAIRS,
  localparam int CFG_W  = 3 * N_PAIRS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [N_CH*CNT_W-1:0] width_i,
  input  logic                  cfg_we_i,
  input  logic [CFG_W-1:0]      cfg_wdata_i,
  input  logic                  wp_set_i,
  output logic [CFG_W-1:0]      cfg_rdata_o,
  output logic                  wp_o,
  output logic [N_CH-1:0]       pwm_o
);
  logic [CFG_W-1:0] cfg;
  logic [N_CH-1:0]  raw;

  pwm_cfg_reg #(.N_PAIRS(N_PAIRS)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .wp_set_i(wp_set_i),
    .cfg_o   (cfg),
    .wp_o    (wp_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_cmp
    pwm_chan_cmp #(.CNT_W(CNT_W)) cmp_i (
      .cnt_i  (cnt_i),
      .width_i(width_i[c*CNT_W +: CNT_W]),
      .raw_o  (raw[c])
    );
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pair_mode_e mode;
    pair_pol_t  pol;
    assign mode        = pair_mode_e'(cfg[2*N_PAIRS + p]);
    assign pol.pol_top = cfg[pol_bit(p, 1'b0)];
    assign pol.pol_bot = cfg[pol_bit(p, 1'b1)];

    pwm_pair_out out_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .pol_i    (pol),
      .raw_top_i(raw[2*p]),
      .raw_bot_i(raw[2*p+1]),
      .top_o    (pwm_o[2*p]),
      .bot_o    (pwm_o[2*p+1])
    );
  end

  assign cfg_rdata_o = cfg;
endmodule

// File: rtl/pwm_pair_stage_chk.sv
module pwm_pair_stage_chk #(
  parameter int CNT_W   = 10,
  parameter int N_PAIRS = 3,
  localparam int N_CH   = 2 * N_PAIRS,
  localparam int CFG_W  = 3 * N_PAIRS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH*CNT_W-1:0] width_i,
  input logic                  wp_set_i,
  input logic [CFG_W-1:0]      cfg_rdata_o,
  input logic                  wp_o,
  input logic [N_CH-1:0]       pwm_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_o |=> wp_o);

  assert_lock_freezes_cfg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_o |=> $stable(cfg_rdata_o));

  assert_lock_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wp_o) |-> $past(wp_set_i));

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair_chk
    // complementary, equal polarity: the two sides always differ
    assert_compl_differ_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && $past(!cfg_rdata_o[2*N_PAIRS+p] &&
                          (cfg_rdata_o[2*p] == cfg_rdata_o[2*p+1])))
      |-> (pwm_o[2*p] != pwm_o[2*p+1]));

    // independent, both positive, equal widths: both sides agree
    assert_indep_equal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && $past(cfg_rdata_o[2*N_PAIRS+p] &&
                          !cfg_rdata_o[2*p] && !cfg_rdata_o[2*p+1] &&
                          (width_i[2*p*CNT_W +: CNT_W] == width_i[(2*p+1)*CNT_W +: CNT_W])))
      |-> (pwm_o[2*p] == pwm_o[2*p+1]));
  end
endmodule

bind pwm_pair_stage pwm_pair_stage_chk #(.CNT_W(CNT_W), .N_PAIRS(N_PAIRS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .width_i    (width_i),
  .wp_set_i   (wp_set_i),
  .cfg_rdata_o(cfg_rdata_o),
  .wp_o       (wp_o),
  .pwm_o      (pwm_o)
);

// File: tb/pwm_pair_stage_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_stage_tb_top;
  localparam int CNT_W = 10;
  localparam int NP    = 3;
  localparam int NCH   = 6;
  localparam int CFGW  = 9;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [CNT_W-1:0]     cnt_i = '0;
  logic [NCH*CNT_W-1:0] width_i;
  logic                 cfg_we_i = 1'b0;
  logic [CFGW-1:0]      cfg_wdata_i = '0;
  logic                 wp_set_i = 1'b0;
  logic [CFGW-1:0]      cfg_rdata_o;
  logic                 wp_o;
  logic [NCH-1:0]       pwm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_pair_stage #(.CNT_W(CNT_W), .N_PAIRS(NP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .width_i(width_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .wp_set_i(wp_set_i),
    .cfg_rdata_o(cfg_rdata_o), .wp_o(wp_o), .pwm_o(pwm_o)
  );

  // widths w5..w0 = 300,300,10,200,50,100
  localparam logic [NCH*CNT_W-1:0] W_BASE =
    {10'd300, 10'd300, 10'd10, 10'd200, 10'd50, 10'd100};

  // {cfg[8:0], cnt[9:0], expected pwm[5:0]}
  localparam int VN = 8;
  localparam logic [24:0] VEC [VN] = '{
    {9'h000, 10'd50,   6'b010101},  // R1 R3 below width
    {9'h000, 10'd100,  6'b010101},  // R9 equal
    {9'h000, 10'd101,  6'b010110},  // R9 one above, R3
    {9'h1C0, 10'd50,   6'b110111},  // R4 independent
    {9'h1FF, 10'd50,   6'b001000},  // R2 all negative
    {9'h001, 10'd250,  6'b011011},  // R5 top A negative
    {9'h042, 10'd60,   6'b010111},  // R5 pair A indep, bottom A negative
    {9'h000, 10'd1023, 6'b101010}   // R3 counter at top
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic write_cfg(input logic [CFGW-1:0] v, input logic lock);
    cfg_wdata_i = v;
    cfg_we_i    = 1'b1;
    wp_set_i    = lock;
    tick();
    cfg_we_i = 1'b0;
    wp_set_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    width_i = W_BASE;
    #12;
    chk("R6 pwm", 32'(pwm_o), 32'h0);
    chk("R6 cfg", 32'(cfg_rdata_o), 32'h0);
    chk("R6 wp", 32'(wp_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < VN; i++) begin
      cnt_i = VEC[i][15:6];
      write_cfg(VEC[i][24:16], 1'b0);
      tick();
      chk($sformatf("R1-table vec%0d", i), 32'(pwm_o), 32'(VEC[i][5:0]));
    end

    // R8: output changes only after the next edge
    write_cfg(9'h000, 1'b0);
    cnt_i = 10'd50;
    tick();
    chk("R8 settled", 32'(pwm_o[0]), 32'h1);
    cnt_i = 10'd150;
    #1;
    chk("R8 before edge", 32'(pwm_o[0]), 32'h1);
    tick();
    chk("R8 after edge", 32'(pwm_o[0]), 32'h0);

    // R3: bottom width ignored in complementary mode
    cnt_i = 10'd60;
    width_i[CNT_W +: CNT_W] = 10'd1023;
    tick();
    chk("R3 bottom width ignored", 32'(pwm_o[1]), 32'h0);
    width_i = W_BASE;

    // R9: maximum width always high
    width_i[0 +: CNT_W] = 10'd1023;
    cnt_i = 10'd1023;
    tick();
    chk("R9 max width", 32'(pwm_o[0]), 32'h1);
    width_i = W_BASE;

    // R7: write and lock in the same cycle
    cnt_i = 10'd50;
    write_cfg(9'h1C0, 1'b1);
    chk("R7 same-cycle write", 32'(cfg_rdata_o), 32'h1C0);
    chk("R7 lock set", 32'(wp_o), 32'h1);
    write_cfg(9'h000, 1'b0);
    tick();
    chk("R7 write ignored cfg", 32'(cfg_rdata_o), 32'h1C0);
    chk("R7 write ignored pwm", 32'(pwm_o), 32'b110111);
    chk("R7 lock held", 32'(wp_o), 32'h1);

    rst_ni = 1'b0;
    #1;
    chk("R7 reset clears lock", 32'(wp_o), 32'h0);
    chk("R6 reset cfg", 32'(cfg_rdata_o), 32'h0);
    chk("R6 reset pwm", 32'(pwm_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    write_cfg(9'h1C0, 1'b0);
    chk("R7 writable after reset", 32'(cfg_rdata_o), 32'h1C0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule